// File: doc/BRIEF.md
# Jacobian Point Doubling Sequencer

The block doubles an elliptic-curve point given in Jacobian projective coordinates on a short-Weierstrass curve whose `a` coefficient is -3. It does no field arithmetic itself. It walks a fixed program of eighteen micro-operations, and each one names an operation kind, two source slots and a destination slot. Every micro-operation goes to an external shared modular ALU through a start/done handshake, and the returned value is written into a small register file.

The register file has slots for the input point, the result point and five temporaries. One read-only slot carries a constant input: the inverse of two modulo the field prime. The program uses that constant to halve instead of dividing. It forms three times a value as two additions, with no multiply. The program has no branches. An input with Z equal to zero comes out with Z equal to zero through the normal arithmetic, and the caller treats that as the point at infinity.

Top module: `jdbl_seq`

## Requirements
- R1: After reset, `busy`, `done` and `alu_start` are low and `rx`, `ry`, `rz` read zero.
- R2: One doubling issues exactly 18 ALU requests. Each `alu_start` is a one-cycle pulse, and no request is issued until the previous one has returned `alu_done`.
- R3: The ALU op codes are 0 for multiply, 1 for add and 2 for subtract (`alu_result` = a*b, a+b, a-b mod q). The requests use the kinds 0,2,1,0,1,1,1,0,0,0,0,0,0,1,2,2,0,2 in that order.
- R4: The first request multiplies pz by itself (a = b = pz). The twelfth request takes the `delta` input as its b operand. No request writes the constant slot.
- R5: When the run ends, (rx, ry, rz) equals 2P with M = 3(X-Z²)(X+Z²), S = 4XY², rx = M²-2S, ry = M(S-rx)-8Y⁴ and rz = 2YZ, all modulo q.
- R6: `done` goes high for exactly one cycle, in the cycle after the ALU result of the final request is written. `rx`, `ry`, `rz` then hold until the next accepted `start`.
- R7: An input point with pz = 0 gives rz = 0.
- R8: While a request is outstanding, `alu_op`, `alu_a` and `alu_b` stay stable.
- R9: `start` is accepted only while `busy` is low. A `start` pulse during a run has no effect on that run's result.
- R10: An `alu_done` pulse while the block is idle changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a doubling of (px, py, pz) |
| px | input | WIDTH | Input X |
| py | input | WIDTH | Input Y |
| pz | input | WIDTH | Input Z |
| delta | input | WIDTH | Inverse of two modulo q |
| rx | output | WIDTH | Result X |
| ry | output | WIDTH | Result Y |
| rz | output | WIDTH | Result Z |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| alu_start | output | 1 | Request to the modular ALU |
| alu_op | output | 2 | Operation kind of the request |
| alu_a | output | WIDTH | First operand |
| alu_b | output | WIDTH | Second operand |
| alu_result | input | WIDTH | ALU result, valid with alu_done |
| alu_done | input | 1 | ALU completion pulse |

## Verification
Doublings run on several unrelated points at ALU latencies of one and five cycles. A wrong slot index or op kind then shows up as a numeric mismatch against the textbook formula, and handshake slips show up at the longer latency. A point with Z = 0 confirms that the zero carries through to rz. A point with X = 0 and Y = q-1 exercises the wraparound of the subtractions. A start pulse during a run and a stray ALU completion while idle confirm that neither disturbs the results.

// File: rtl/jdbl_pkg.sv
package jdbl_pkg;

  localparam int NUM_OPS   = 18;
  localparam int NUM_SLOTS = 11;
  localparam int PC_W      = $clog2(NUM_OPS);

  typedef enum logic [1:0] {
    OP_MUL = 2'd0,
    OP_ADD = 2'd1,
    OP_SUB = 2'd2
  } op_e;

  typedef enum logic [3:0] {
    SL_PX    = 4'd0,
    SL_PY    = 4'd1,
    SL_PZ    = 4'd2,
    SL_RX    = 4'd3,
    SL_RY    = 4'd4,
    SL_RZ    = 4'd5,
    SL_T1    = 4'd6,
    SL_T2    = 4'd7,
    SL_T3    = 4'd8,
    SL_T4    = 4'd9,
    SL_T5    = 4'd10,
    SL_DELTA = 4'd11
  } slot_e;

  typedef struct packed {
    op_e   op;
    slot_e src_a;
    slot_e src_b;
    slot_e dst;
  } uop_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } state_e;

  function automatic uop_t mk(input op_e o, input slot_e a, input slot_e b, input slot_e d);
    uop_t u;
    u.op = o; u.src_a = a; u.src_b = b; u.dst = d;
    return u;
  endfunction

  // Doubling program: 3*M built by two adds, halving by delta multiply.
  function automatic uop_t program_step(input logic [PC_W-1:0] idx);
    case (idx)
      5'd0:    return mk(OP_MUL, SL_PZ, SL_PZ,    SL_T1); // Z^2
      5'd1:    return mk(OP_SUB, SL_PX, SL_T1,    SL_T2); // X - Z^2
      5'd2:    return mk(OP_ADD, SL_PX, SL_T1,    SL_T3); // X + Z^2
      5'd3:    return mk(OP_MUL, SL_T3, SL_T2,    SL_T4); // X^2 - Z^4
      5'd4:    return mk(OP_ADD, SL_T4, SL_T4,    SL_T1); // twice
      5'd5:    return mk(OP_ADD, SL_T1, SL_T4,    SL_T2); // M
      5'd6:    return mk(OP_ADD, SL_PY, SL_PY,    SL_RY); // 2Y
      5'd7:    return mk(OP_MUL, SL_PZ, SL_RY,    SL_RZ); // 2YZ
      5'd8:    return mk(OP_MUL, SL_RY, SL_RY,    SL_T1); // 4Y^2
      5'd9:    return mk(OP_MUL, SL_PX, SL_T1,    SL_T3); // S
      5'd10:   return mk(OP_MUL, SL_T1, SL_T1,    SL_T4); // 16Y^4
      5'd11:   return mk(OP_MUL, SL_T4, SL_DELTA, SL_T5); // 8Y^4
      5'd12:   return mk(OP_MUL, SL_T2, SL_T2,    SL_T4); // M^2
      5'd13:   return mk(OP_ADD, SL_T3, SL_T3,    SL_T1); // 2S
      5'd14:   return mk(OP_SUB, SL_T4, SL_T1,    SL_RX); // X3
      5'd15:   return mk(OP_SUB, SL_T3, SL_RX,    SL_T1); // S - X3
      5'd16:   return mk(OP_MUL, SL_T1, SL_T2,    SL_T3); // M(S - X3)
      default: return mk(OP_SUB, SL_T3, SL_T5,    SL_RY); // Y3
    endcase
  endfunction

endpackage

// File: rtl/jdbl_rom.sv
module jdbl_rom
  import jdbl_pkg::*;
(
  input  logic [PC_W-1:0] pc,
  output uop_t            uop
);
  assign uop = program_step(pc);
endmodule

// File: rtl/jdbl_regfile.sv
module jdbl_regfile
  import jdbl_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] px,
  input  logic [WIDTH-1:0] py,
  input  logic [WIDTH-1:0] pz,
  input  logic [WIDTH-1:0] konst,
  input  logic             wr_en,
  input  slot_e            wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  slot_e            rd_a_idx,
  input  slot_e            rd_b_idx,
  output logic [WIDTH-1:0] rd_a,
  output logic [WIDTH-1:0] rd_b,
  output logic [WIDTH-1:0] rx,
  output logic [WIDTH-1:0] ry,
  output logic [WIDTH-1:0] rz
);

  logic [WIDTH-1:0] slots [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) slots[i] <= '0;
    end else if (load) begin
      slots[SL_PX] <= px;
      slots[SL_PY] <= py;
      slots[SL_PZ] <= pz;
    end else if (wr_en && (wr_idx != SL_DELTA)) begin
      slots[wr_idx] <= wr_data;
    end
  end

  assign rd_a = (rd_a_idx == SL_DELTA) ? konst : slots[rd_a_idx];
  assign rd_b = (rd_b_idx == SL_DELTA) ? konst : slots[rd_b_idx];
  assign rx   = slots[SL_RX];
  assign ry   = slots[SL_RY];
  assign rz   = slots[SL_RZ];

  AST_NO_CONST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != SL_DELTA)) else $error("constant slot written"); // R4

  AST_LOAD_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !wr_en) else $error("load collides with write"); // R9

endmodule

// File: rtl/jdbl_ctrl.sv
module jdbl_ctrl
  import jdbl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            alu_done,
  output logic [PC_W-1:0] pc,
  output logic            load,
  output logic            alu_start,
  output logic            wr_en,
  output logic            waiting,
  output logic            last_write,
  output logic            busy,
  output logic            done
);

  localparam logic [PC_W-1:0] LAST_PC = PC_W'(NUM_OPS - 1);

  state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pc    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          pc    <= '0;
          state <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (alu_done) begin
          if (pc == LAST_PC) state <= ST_FIN;
          else begin
            pc    <= pc + 1'b1;
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign load       = (state == ST_IDLE) && start;
  assign alu_start  = (state == ST_ISSUE);
  assign waiting    = (state == ST_WAIT);
  assign wr_en      = waiting && alu_done;
  assign last_write = wr_en && (pc == LAST_PC);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_FIN);

  // request counter for the issue-count check
  logic [PC_W:0] issued;
  always_ff @(posedge clk) begin
    if (!rst_n)         issued <= '0;
    else if (load)      issued <= '0;
    else if (alu_start) issued <= issued + 1'b1;
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    alu_start |=> !alu_start) else $error("start longer than one cycle"); // R2

  AST_NO_ISSUE_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !alu_done) |=> !alu_start) else $error("issue before done"); // R2

  AST_ISSUE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (issued == (PC_W+1)'(NUM_OPS))) else $error("wrong request count"); // R2

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_write |=> done) else $error("done not after last write"); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!alu_start && !wr_en)) else $error("activity while idle"); // R10

endmodule

// File: rtl/jdbl_seq.sv
module jdbl_seq
  import jdbl_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] px,
  input  logic [WIDTH-1:0] py,
  input  logic [WIDTH-1:0] pz,
  input  logic [WIDTH-1:0] delta,
  output logic [WIDTH-1:0] rx,
  output logic [WIDTH-1:0] ry,
  output logic [WIDTH-1:0] rz,
  output logic             busy,
  output logic             done,
  output logic             alu_start,
  output logic [1:0]       alu_op,
  output logic [WIDTH-1:0] alu_a,
  output logic [WIDTH-1:0] alu_b,
  input  logic [WIDTH-1:0] alu_result,
  input  logic             alu_done
);

  logic [PC_W-1:0] pc;
  logic            load;
  logic            wr_en;
  logic            waiting;
  logic            last_write;
  uop_t            uop;

  jdbl_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .alu_done   (alu_done),
    .pc         (pc),
    .load       (load),
    .alu_start  (alu_start),
    .wr_en      (wr_en),
    .waiting    (waiting),
    .last_write (last_write),
    .busy       (busy),
    .done       (done)
  );

  jdbl_rom u_rom (
    .pc  (pc),
    .uop (uop)
  );

  jdbl_regfile #(.WIDTH(WIDTH)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .px       (px),
    .py       (py),
    .pz       (pz),
    .konst    (delta),
    .wr_en    (wr_en),
    .wr_idx   (uop.dst),
    .wr_data  (alu_result),
    .rd_a_idx (uop.src_a),
    .rd_b_idx (uop.src_b),
    .rd_a     (alu_a),
    .rd_b     (alu_b),
    .rx       (rx),
    .ry       (ry),
    .rz       (rz)
  );

  assign alu_op = uop.op;

  AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !alu_done) |=> ($stable(alu_op) && $stable(alu_a) && $stable(alu_b)))
    else $error("operands moved during request"); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(rx) && $stable(ry) && $stable(rz)))
    else $error("result changed while idle"); // R6

  AST_FIRST_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_start && pc == '0) |-> (alu_op == 2'd0 && alu_a == alu_b))
    else $error("first request is not a square"); // R4

endmodule

// File: tb/jdbl_seq_test.sv
module jdbl_seq_test;
  localparam int W     = 16;
  localparam int Q     = 65521;
  localparam int DELTA = (Q + 1) / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] px = '0, py = '0, pz = '0;
  logic [W-1:0] delta = W'(DELTA);
  logic [W-1:0] rx, ry, rz;
  logic         busy, done, alu_start;
  logic [1:0]   alu_op;
  logic [W-1:0] alu_a, alu_b, alu_result;
  logic         alu_done;
  logic         model_done = 1'b0;
  logic         stray_done = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  assign alu_done = model_done | stray_done;

  jdbl_seq #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .px(px), .py(py), .pz(pz), .delta(delta),
    .rx(rx), .ry(ry), .rz(rz), .busy(busy), .done(done),
    .alu_start(alu_start), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
    .alu_result(alu_result), .alu_done(alu_done)
  );

  function automatic int fmul(int a, int b);
    longint p;
    p = longint'(a) * longint'(b);
    return int'(p % Q);
  endfunction
  function automatic int fadd(int a, int b); return (a + b) % Q; endfunction
  function automatic int fsub(int a, int b); return (a - b + Q) % Q; endfunction

  // ALU model with adjustable latency and a request log
  int lat = 1;
  int remain = 0;
  int n_req = 0;
  logic [1:0] cap_op;
  int cap_a, cap_b;
  logic [1:0] log_op [32];
  int log_a [32];
  int log_b [32];
  logic hold_bad = 1'b0;
  logic dbl_start = 1'b0;
  logic early_start = 1'b0;

  always @(posedge clk) begin
    model_done <= 1'b0;
    if (!rst_n) begin
      remain <= 0;
    end else if (remain > 0) begin
      if (alu_start) early_start <= 1'b1;
      if (alu_op != cap_op || int'(alu_a) != cap_a || int'(alu_b) != cap_b) hold_bad <= 1'b1;
      remain <= remain - 1;
      if (remain == 1) begin
        model_done <= 1'b1;
        case (cap_op)
          2'd0:    alu_result <= W'(fmul(cap_a, cap_b));
          2'd1:    alu_result <= W'(fadd(cap_a, cap_b));
          default: alu_result <= W'(fsub(cap_a, cap_b));
        endcase
      end
    end else if (alu_start) begin
      cap_op <= alu_op;
      cap_a  <= int'(alu_a);
      cap_b  <= int'(alu_b);
      if (n_req < 32) begin
        log_op[n_req] <= alu_op;
        log_a[n_req]  <= int'(alu_a);
        log_b[n_req]  <= int'(alu_b);
      end
      n_req  <= n_req + 1;
      remain <= lat;
    end
    if (alu_start && model_done) dbl_start <= 1'b1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output int cyc, output int done_cycles);
    cyc = 0;
    done_cycles = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (done) done_cycles = 1;
    @(negedge clk);
    if (done) done_cycles++;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // expected values from the textbook formula for a = -3
  task automatic expect_dbl(input int x, input int y, input int z,
                            output int ex, output int ey, output int ez);
    int z2, m, y2, s, y4;
    z2 = fmul(z, z);
    m  = fmul(3, fmul(fsub(x, z2), fadd(x, z2)));
    y2 = fmul(y, y);
    s  = fmul(4, fmul(x, y2));
    y4 = fmul(y2, y2);
    ex = fsub(fmul(m, m), fmul(2, s));
    ey = fsub(fmul(m, fsub(s, ex)), fmul(8, y4));
    ez = fmul(2, fmul(y, z));
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "alu_start", int'(alu_start), 0);
    check("R1", "rx|ry|rz", int'(rx | ry | rz), 0);
  endtask

  task automatic test_double(input int x, input int y, input int z, input int l);
    int ex, ey, ez, cyc, dc;
    int kinds [18] = '{0, 2, 1, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 1, 2, 2, 0, 2};
    int kind_bad;
    lat = l;
    n_req = 0;
    hold_bad = 1'b0;
    dbl_start = 1'b0;
    early_start = 1'b0;
    px = W'(x); py = W'(y); pz = W'(z);
    pulse_start();
    px = '0; py = '0; pz = '0;
    wait_done(cyc, dc);
    expect_dbl(x, y, z, ex, ey, ez);
    check("R5", "rx", int'(rx), ex);
    check("R5", "ry", int'(ry), ey);
    check("R5", "rz", int'(rz), ez);
    check("R2", "request count", n_req, 18);
    check("R2", "overlapping request", int'(dbl_start | early_start), 0);
    kind_bad = 0;
    for (int k = 0; k < 18; k++) if (int'(log_op[k]) != kinds[k]) kind_bad++;
    check("R3", "op kind mismatches", kind_bad, 0);
    check("R4", "first a", log_a[0], z);
    check("R4", "first b", log_b[0], z);
    check("R4", "twelfth b is delta", log_b[11], DELTA);
    check("R6", "done cycles", dc, 1);
    check("R8", "operands moved", int'(hold_bad), 0);
    repeat (3) @(negedge clk);
    check("R6", "rx held", int'(rx), ex);
    check("R6", "rz held", int'(rz), ez);
  endtask

  task automatic test_infinity();
    int cyc, dc;
    lat = 2;
    n_req = 0;
    px = 16'd999; py = 16'd4321; pz = '0;
    pulse_start();
    wait_done(cyc, dc);
    check("R7", "rz for pz=0", int'(rz), 0);
  endtask

  task automatic test_start_while_busy();
    int ex, ey, ez, cyc, dc;
    lat = 3;
    n_req = 0;
    px = 16'd321; py = 16'd654; pz = 16'd987;
    pulse_start();
    repeat (10) @(negedge clk);
    px = 16'd11; py = 16'd22; pz = 16'd33;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc, dc);
    expect_dbl(321, 654, 987, ex, ey, ez);
    check("R9", "rx after mid-run start", int'(rx), ex);
    check("R9", "ry after mid-run start", int'(ry), ey);
    check("R9", "rz after mid-run start", int'(rz), ez);
    check("R9", "request count", n_req, 18);
    check("R9", "busy after run", int'(busy), 0);
  endtask

  task automatic test_stray_done();
    int sx, sy, sz;
    sx = int'(rx); sy = int'(ry); sz = int'(rz);
    @(negedge clk);
    stray_done = 1'b1;
    @(negedge clk);
    stray_done = 1'b0;
    @(negedge clk);
    check("R10", "rx", int'(rx), sx);
    check("R10", "ry", int'(ry), sy);
    check("R10", "rz", int'(rz), sz);
    check("R10", "busy", int'(busy), 0);
    check("R10", "alu_start", int'(alu_start), 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_double(1234, 5678, 1, 1);
    test_double(40000, 65520, 777, 5);
    test_double(0, 65520, 65520, 1);
    test_double(31337, 2, 50000, 4);
    test_infinity();
    test_start_while_busy();
    test_stray_done();
    finish_run();
  end

endmodule